// File: doc/BRIEF.md
# Decimal Address to Coincident Select Decoder

This block turns a three-character decimal address into the two select vectors that a 4000-location coincident-selection array needs. One of 50 X lines and one of 80 Y lines goes high, and a location is selected where the two lines cross. Each character holds a decimal digit in 8-4-2-1 form, a check bit and two zone bits. The zone bits of the hundreds character carry the thousands digit, so addresses 0000 to 3999 can be reached.

The block does not decode the full address into one wide value. Each digit is first turned into its own set of lines, and every digit line is a 3-input AND. That AND is only correct because zero is coded as 1010 and because the check bit separates codes that would otherwise match. The hundreds digit is split in two. Its upper bits pick one of five even-hundreds lines. Its lowest bit picks an odd line, and the thousands digit is combined with that odd line. The X lines are the cross of the even-hundreds lines with the units lines. The Y lines are the cross of the thousands/odd groups with the tens lines.

If any character is malformed, a flag is raised and all select lines are held low. A package function maps an (X, Y) index pair back to a linear address. A consumer, or a bench, can use it to confirm the mapping.

Top module: `bcd_coincident_decoder`

## Requirements
- R1: Each character is 7 bits: bit 6 check, bit 5 zone B, bit 4 zone A, bits 3..0 the digit weighted 8,4,2,1. Digits 1 to 9 use their binary code and digit 0 uses 1010.
- R2: For a valid address, the only X line that is high is x_sel[(hundreds/2)*10 + units].
- R3: For a valid address, the only Y line that is high is y_sel[(thousands*2 + hundreds%2)*10 + tens].
- R4: The thousands digit comes from the hundreds character's zone bits as follows: neither set = 0, A only = 1, B only = 2, both set = 3.
- R5: The check bit of every character gives odd parity over all seven bits. A character whose parity is even raises addr_bad.
- R6: If any character has digit code 0000 or any code from 1011 to 1111, addr_bad is raised.
- R7: While addr_bad is high, every x_sel and y_sel bit is 0. While it is low, exactly one bit of each vector is high.
- R8: The zone bits of the tens and units characters do not change x_sel or y_sel, provided the check bit still gives odd parity.
- R9: The package function sel_to_addr maps the index pair from R2 and R3 back to thousands*1000 + hundreds*100 + tens*10 + units.
- R10: The outputs depend only on the present inputs. The block holds no state and uses no clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hund_char | input | 7 | Hundreds character. Its zone bits give the thousands digit. |
| tens_char | input | 7 | Tens character |
| unit_char | input | 7 | Units character |
| x_sel | output | 50 | One-hot X select lines |
| y_sel | output | 80 | One-hot Y select lines |
| addr_bad | output | 1 | Malformed character. All select lines are forced low. |

## Verification
The one-hot assertions assume that a character only counts as valid when its code is legal and its parity is odd. The 3-input AND decoding is only exact on that legal set. The bench's character builder always writes a correct check bit for every legal digit. The parity and illegal-code tests corrupt exactly one field, so that addr_bad is expected to rise and the gating rule takes over. The full sweep of all 4000 addresses keeps zone bits off the tens and units characters. A separate test sets those zone bits, with a parity that matches, to show they have no effect.

// File: rtl/bcd_sel_pkg.sv
// Package: shared character layout, array geometry and the index-to-address helper.
// Assumes: characters use the 7-bit layout C,B,A,8,4,2,1 from MSB to LSB.
package bcd_sel_pkg;

    localparam int DIGITS    = 10;
    localparam int EVEN_GRPS = 5;
    localparam int THOUSANDS = 4;
    localparam int ODD_GRPS  = 2;
    localparam int Y_GRPS    = THOUSANDS * ODD_GRPS;
    localparam int X_LINES   = EVEN_GRPS * DIGITS;
    localparam int Y_LINES   = Y_GRPS * DIGITS;
    localparam int CHAR_W    = 7;

    typedef struct packed {
        logic chk;
        logic zb;
        logic za;
        logic b8;
        logic b4;
        logic b2;
        logic b1;
    } bcd_char_t;

    // Maps an X index and a Y index back to the linear decimal address.
    function automatic int unsigned sel_to_addr(input int unsigned xi, input int unsigned yi);
        int unsigned even_grp;
        int unsigned units;
        int unsigned y_grp;
        int unsigned tens;
        even_grp = xi / DIGITS;
        units    = xi % DIGITS;
        y_grp    = yi / DIGITS;
        tens     = yi % DIGITS;
        return (y_grp / ODD_GRPS) * 1000
             + (even_grp * 2 + (y_grp % ODD_GRPS)) * 100
             + tens * 10 + units;
    endfunction

endpackage

// File: rtl/bcd_digit_lines.sv
// Module: turns one character into ten digit lines, each produced by a 3-input AND.
// Assumes: the AND terms are only exact for legal codes (0001..1010) with odd parity;
//          the legal output reports exactly that condition.
module bcd_digit_lines
    import bcd_sel_pkg::*;
#(
    parameter int N_LINES = DIGITS
) (
    input  bcd_char_t          ch,
    output logic [N_LINES-1:0] lines,
    output logic               legal
);

    logic       cp;
    logic [3:0] code;

    // Strips the zone bits out of the check bit, leaving a parity term for the digit alone.
    always_comb begin
        cp   = ch.chk ^ ch.za ^ ch.zb;
        code = {ch.b8, ch.b4, ch.b2, ch.b1};
    end

    // One 3-input AND per digit line; digit 0 is the 1010 code.
    always_comb begin
        lines    = '0;
        lines[0] =  ch.b8 &  ch.b2 & ~ch.b1;
        lines[1] = ~ch.b8 & ~ch.b4 & ~ch.b2;
        lines[2] = ~ch.b8 & ~ch.b4 & ~ch.b1;
        lines[3] =  ch.b2 &  ch.b1 &  cp;
        lines[4] =  ch.b4 & ~ch.b2 & ~ch.b1;
        lines[5] =  ch.b4 &  ch.b1 &  cp;
        lines[6] =  ch.b4 &  ch.b2 &  cp;
        lines[7] =  ch.b4 &  ch.b2 &  ch.b1;
        lines[8] =  ch.b8 & ~ch.b2 & ~ch.b1;
        lines[9] =  ch.b8 & ~ch.b2 &  ch.b1;
    end

    // Legal when the code is in 1..10 and the whole character has odd parity.
    always_comb begin
        legal = (code >= 4'd1) && (code <= 4'd10) && (^ch);
    end

    // A legal character must light exactly one digit line.
    always_comb begin
        if (legal) assert ($countones(lines) == 1) else $error("AST_DIGIT_ONEHOT"); // R1
    end

endmodule

// File: rtl/bcd_hundreds_split.sv
// Module: splits the hundreds character into even-hundreds lines, odd lines and
//         thousands lines (from the zone bits).
// Assumes: the even-hundreds AND terms are only exact for legal codes; the legality
//          flag comes from a full digit decode of the same character.
module bcd_hundreds_split
    import bcd_sel_pkg::*;
#(
    parameter int N_EVEN = EVEN_GRPS,
    parameter int N_ODD  = ODD_GRPS,
    parameter int N_THOU = THOUSANDS
) (
    input  bcd_char_t         ch,
    output logic [N_EVEN-1:0] even_ln,
    output logic [N_ODD-1:0]  odd_ln,
    output logic [N_THOU-1:0] thou_ln,
    output logic              legal
);

    logic [DIGITS-1:0] dig_ln;

    bcd_digit_lines #(.N_LINES(DIGITS)) u_full (
        .ch    (ch),
        .lines (dig_ln),
        .legal (legal)
    );

    // Even-hundreds lines from bits 8,4,2 only; group 0 covers codes 1010 and 0001.
    always_comb begin
        even_ln    = '0;
        even_ln[0] = (~ch.b8 & ~ch.b4 & ~ch.b2) | (ch.b8 & ~ch.b4 & ch.b2);
        even_ln[1] = ~ch.b8 & ~ch.b4 &  ch.b2;
        even_ln[2] = ~ch.b8 &  ch.b4 & ~ch.b2;
        even_ln[3] = ~ch.b8 &  ch.b4 &  ch.b2;
        even_ln[4] =  ch.b8 & ~ch.b4 & ~ch.b2;
    end

    // The odd line comes from the low-order bit; the thousands lines decode zone B,A.
    always_comb begin
        odd_ln     = {ch.b1, ~ch.b1};
        thou_ln    = '0;
        thou_ln[0] = ~ch.zb & ~ch.za;
        thou_ln[1] = ~ch.zb &  ch.za;
        thou_ln[2] =  ch.zb & ~ch.za;
        thou_ln[3] =  ch.zb &  ch.za;
    end

    // The even group must agree with the pair of full digit lines it stands for.
    always_comb begin
        if (legal) begin
            for (int k = 0; k < N_EVEN; k++) begin
                assert (even_ln[k] == (dig_ln[2*k] | dig_ln[2*k+1]))
                    else $error("AST_EVEN_GROUP_MATCH"); // R2
            end
            assert (odd_ln[1] == (dig_ln[1] | dig_ln[3] | dig_ln[5] | dig_ln[7] | dig_ln[9]))
                else $error("AST_ODD_LINE_MATCH"); // R3
        end
        assert ($onehot(thou_ln)) else $error("AST_THOU_ONEHOT"); // R4
    end

endmodule

// File: rtl/bcd_sel_matrix.sv
// Module: crosses two sets of lines into A_N*B_N outputs; output a*B_N+b is high when
//         line a, line b and the enable are all high.
// Assumes: each input set is one-hot or all zero.
module bcd_sel_matrix #(
    parameter int A_N   = 5,
    parameter int B_N   = 10,
    localparam int OUT_N = A_N * B_N
) (
    input  logic [A_N-1:0]   a_ln,
    input  logic [B_N-1:0]   b_ln,
    input  logic             en,
    output logic [OUT_N-1:0] out_ln
);

    // One crossing point per output line.
    for (genvar ia = 0; ia < A_N; ia++) begin : g_row
        for (genvar ib = 0; ib < B_N; ib++) begin : g_col
            assign out_ln[ia*B_N + ib] = en & a_ln[ia] & b_ln[ib];
        end
    end

    // With an enable and one-hot inputs, exactly one crossing point is active.
    always_comb begin
        if (en && $onehot(a_ln) && $onehot(b_ln))
            assert ($countones(out_ln) == 1) else $error("AST_CROSS_ONEHOT"); // R7
        if (!en)
            assert (out_ln == '0) else $error("AST_CROSS_QUIET"); // R7
    end

endmodule

// File: rtl/bcd_coincident_decoder.sv
// Module: top level. Converts a three-character decimal address into one-hot X and Y
//         select vectors for a 4000-location coincident array, and flags bad input.
// Assumes: combinational use only; the caller registers the outputs if it needs to.
module bcd_coincident_decoder
    import bcd_sel_pkg::*;
(
    input  logic [CHAR_W-1:0]  hund_char,
    input  logic [CHAR_W-1:0]  tens_char,
    input  logic [CHAR_W-1:0]  unit_char,
    output logic [X_LINES-1:0] x_sel,
    output logic [Y_LINES-1:0] y_sel,
    output logic               addr_bad
);

    logic [DIGITS-1:0]    unit_ln;
    logic [DIGITS-1:0]    tens_ln;
    logic [EVEN_GRPS-1:0] even_ln;
    logic [ODD_GRPS-1:0]  odd_ln;
    logic [THOUSANDS-1:0] thou_ln;
    logic [Y_GRPS-1:0]    ygrp_ln;
    logic                 unit_ok;
    logic                 tens_ok;
    logic                 hund_ok;

    bcd_digit_lines #(.N_LINES(DIGITS)) u_units (
        .ch    (bcd_char_t'(unit_char)),
        .lines (unit_ln),
        .legal (unit_ok)
    );

    bcd_digit_lines #(.N_LINES(DIGITS)) u_tens (
        .ch    (bcd_char_t'(tens_char)),
        .lines (tens_ln),
        .legal (tens_ok)
    );

    bcd_hundreds_split #(.N_EVEN(EVEN_GRPS), .N_ODD(ODD_GRPS), .N_THOU(THOUSANDS)) u_hund (
        .ch      (bcd_char_t'(hund_char)),
        .even_ln (even_ln),
        .odd_ln  (odd_ln),
        .thou_ln (thou_ln),
        .legal   (hund_ok)
    );

    // Any malformed character blocks every select line.
    always_comb begin
        addr_bad = ~(unit_ok & tens_ok & hund_ok);
    end

    // Thousands crossed with odd hundreds gives the eight Y groups (index th*2+odd).
    bcd_sel_matrix #(.A_N(THOUSANDS), .B_N(ODD_GRPS)) u_ygrp (
        .a_ln   (thou_ln),
        .b_ln   (odd_ln),
        .en     (1'b1),
        .out_ln (ygrp_ln)
    );

    bcd_sel_matrix #(.A_N(EVEN_GRPS), .B_N(DIGITS)) u_xmat (
        .a_ln   (even_ln),
        .b_ln   (unit_ln),
        .en     (~addr_bad),
        .out_ln (x_sel)
    );

    bcd_sel_matrix #(.A_N(Y_GRPS), .B_N(DIGITS)) u_ymat (
        .a_ln   (ygrp_ln),
        .b_ln   (tens_ln),
        .en     (~addr_bad),
        .out_ln (y_sel)
    );

    // Port-level guarantees on the two select vectors.
    always_comb begin
        if (!addr_bad) begin
            assert ($countones(x_sel) == 1) else $error("AST_X_ONEHOT"); // R2
            assert ($countones(y_sel) == 1) else $error("AST_Y_ONEHOT"); // R3
        end else begin
            assert (x_sel == '0 && y_sel == '0) else $error("AST_BAD_QUIET"); // R7
        end
    end

endmodule

// File: tb/bcd_coincident_decoder_tb_top.sv
// Bench: directed tests, one task per scenario; expected indexes come from R2/R3.
module bcd_coincident_decoder_tb_top;
    import bcd_sel_pkg::*;

    logic clk = 1'b0;
    logic [CHAR_W-1:0]  hund_char = '0;
    logic [CHAR_W-1:0]  tens_char = '0;
    logic [CHAR_W-1:0]  unit_char = '0;
    logic [X_LINES-1:0] x_sel;
    logic [Y_LINES-1:0] y_sel;
    logic               addr_bad;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    bcd_coincident_decoder dut_i (
        .hund_char (hund_char),
        .tens_char (tens_char),
        .unit_char (unit_char),
        .x_sel     (x_sel),
        .y_sel     (y_sel),
        .addr_bad  (addr_bad)
    );

    // R1 layout: {C, B, A, 8, 4, 2, 1}; digit 0 is coded 1010; C gives odd parity (R5).
    function automatic logic [6:0] mk_char(input int d, input int z);
        logic [3:0] code;
        logic [1:0] zn;
        code = (d == 0) ? 4'd10 : 4'(d);
        zn   = 2'(z);
        return {~^{zn, code}, zn, code};
    endfunction

    function automatic int first_set_x(input logic [X_LINES-1:0] v);
        for (int i = 0; i < X_LINES; i++) if (v[i]) return i;
        return -1;
    endfunction

    function automatic int first_set_y(input logic [Y_LINES-1:0] v);
        for (int i = 0; i < Y_LINES; i++) if (v[i]) return i;
        return -1;
    endfunction

    task automatic check(input bit ok, input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [6:0] h, input logic [6:0] t, input logic [6:0] u);
        @(negedge clk);
        hund_char = h;
        tens_char = t;
        unit_char = u;
        #2;
    endtask

    // Drives address a (0..3999) with optional zones on tens/units and checks R2, R3, R9.
    task automatic check_addr(input int a, input int zt, input int zu, input string req);
        int th, h, t, u, xi, yi, gx, gy;
        logic [X_LINES-1:0] ex;
        logic [Y_LINES-1:0] ey;
        bit ok;
        th = a / 1000; h = (a / 100) % 10; t = (a / 10) % 10; u = a % 10;
        apply(mk_char(h, th), mk_char(t, zt), mk_char(u, zu));
        xi = (h / 2) * 10 + u;
        yi = (th * 2 + h % 2) * 10 + t;
        ex = '0; ex[xi] = 1'b1;
        ey = '0; ey[yi] = 1'b1;
        gx = first_set_x(x_sel);
        gy = first_set_y(y_sel);
        ok = (x_sel == ex) && (y_sel == ey) && !addr_bad && (gx >= 0) && (gy >= 0)
             && (sel_to_addr(unsigned'(gx), unsigned'(gy)) == unsigned'(a));
        check(ok, req, {x_sel, 78'(a)}, {ex, 78'(a)});
    endtask

    task automatic expect_bad(input string req);
        check(addr_bad && x_sel == '0 && y_sel == '0, req,
              {addr_bad, 127'({x_sel, y_sel})}, {1'b1, 127'd0});
    endtask

    // Inputs idle at all-zero characters: code 0000 is illegal.
    task automatic t_idle_state();
        apply('0, '0, '0);
        expect_bad("R6 idle zero chars");
        check(!$isunknown({x_sel, y_sel, addr_bad}), "R10 outputs known", 128'(addr_bad), 128'd1);
    endtask

    // Corner addresses and the digit-zero code.
    task automatic t_corners();
        check_addr(0,    0, 0, "R1 address 0000 (zero code 1010)");
        check_addr(3999, 0, 0, "R2 R3 address 3999");
        check_addr(1999, 0, 0, "R4 thousands A only");
        check_addr(2000, 0, 0, "R4 thousands B only");
        check_addr(3100, 0, 0, "R4 thousands A and B");
        check_addr(901,  0, 0, "R3 odd hundreds");
    endtask

    // Exhaustive sweep of the valid range, with the round-trip through the helper.
    task automatic t_sweep();
        for (int a = 0; a < 4000; a++) check_addr(a, 0, 0, "R9 sweep round trip");
    endtask

    // Zone bits on tens/units must not move the selection.
    task automatic t_zone_ignored();
        for (int z = 0; z < 4; z++) begin
            check_addr(2573, z, 3 - z, "R8 zones on tens/units ignored");
            check_addr(1468, 3 - z, z, "R8 zones on tens/units ignored");
        end
    endtask

    // Flipping the check bit of any one character must raise the flag.
    task automatic t_parity();
        logic [6:0] h, t, u;
        h = mk_char(7, 2); t = mk_char(3, 0); u = mk_char(5, 0);
        apply(h ^ 7'h40, t, u); expect_bad("R5 hundreds parity");
        apply(h, t ^ 7'h40, u); expect_bad("R5 tens parity");
        apply(h, t, u ^ 7'h40); expect_bad("R5 units parity");
        apply(h, t ^ 7'h20, u); expect_bad("R5 zone flip without check");
        apply(h, t, u);
        check(!addr_bad, "R5 restored parity accepted", 128'(addr_bad), 128'd0);
    endtask

    // Illegal codes (0000 and 1011..1111) in each position, with correct parity.
    task automatic t_illegal();
        logic [6:0] bad;
        for (int c = 11; c < 17; c++) begin
            bad = {~^(4'(c)), 2'b00, 4'(c)};
            apply(bad, mk_char(4, 0), mk_char(4, 0)); expect_bad("R6 illegal hundreds");
            apply(mk_char(4, 1), bad, mk_char(4, 0)); expect_bad("R6 illegal tens");
            apply(mk_char(4, 1), mk_char(4, 0), bad); expect_bad("R7 illegal units gated");
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        t_idle_state();
        t_corners();
        t_zone_ignored();
        t_parity();
        t_illegal();
        t_sweep();
        finish_run();
    end

endmodule